// File: doc/BRIEF.md
# Queue Head Transaction Execute Controller

This block sequences the execute phase of a USB 2.0 host controller for one queue head. It starts on a single-cycle `start` pulse. It first checks two entry conditions: the first transaction must fit in the remaining micro-frame time, and an interrupt endpoint must have a nonzero transaction budget. If both hold, it flags reclamation and then issues transaction requests one at a time. It waits for each result before it decides whether to issue another.

A small budget counter bounds the loop. It is loaded on entry and is reduced by one for every transaction that completes. Each result carries a handshake code, an error flag and a data PID mismatch flag. Together with the live Active bit and the time-fit signal, the result decides whether the loop goes on. The block also keeps a NAK reload count that it decrements on NAK or NYET answers to IN transactions. When the block leaves the state, it raises a one-cycle done pulse with an exit reason, and it indicates whether the queue head overlay must be written back. The endpoint configuration inputs (`is_intr`, `is_in`, `mult`, `rl`) must be held stable from `start` until `done`.

Top module: `qh_exec_ctrl`

## Requirements
- R1: At entry, if `fits` is low, the block raises `done` with exit code 1 and issues no `txn_req`, no `reclaim_set` and no `wb_req`.
- R2: At entry, for an interrupt endpoint (`is_intr`=1) with `mult`=0, the block raises `done` with exit code 2 and issues no `txn_req`.
- R3: When the entry checks pass, `reclaim_set` pulses for exactly one cycle, in the cycle just before the first `txn_req`. It does not pulse again during the same entry.
- R4: The budget loads `mult` for interrupt endpoints and 1 for all others. Every result decrements it. When the result leaves it at zero (and no earlier rule applies), the block exits with code 3. The number of `txn_req` pulses therefore never exceeds the budget.
- R5: A handshake other than ACK (`rsp_hs` encoding: 0 ACK, 1 NAK, 2 NYET, 3 STALL) ends the loop with exit code 4.
- R6: `rsp_err` ends the loop with exit code 5, and it takes priority over the handshake code.
- R7: After an ACK with budget remaining, a low `active` ends the loop with exit code 6.
- R8: After an ACK with budget remaining and `active` high, a low `fits` ends the loop with exit code 7.
- R9: A data PID mismatch on an IN transaction still consumes budget. The loop continues only on an interrupt endpoint whose remaining budget is greater than one. Otherwise it exits with code 0.
- R10: `nak_cnt` loads `nak_init` on `start`. It decrements by one on each error-free NAK or NYET result of an IN transaction when `rl` is nonzero. It does not go below zero, and OUT transactions leave it unchanged.
- R11: `wb_req` pulses together with `done` for every exit after at least one transaction. The one exception is an exit on NAK or NYET with `rl`=0 and `rsp_cerr_chg` low.
- R12: `done` lasts one cycle and `exit_code` is valid with it. `start` is ignored while the block is engaged, and `rsp_valid` is ignored when no result is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Enter the execute state (pulse) |
| is_intr | input | 1 | Queue head is an interrupt endpoint |
| is_in | input | 1 | Transfer direction is IN |
| mult | input | CNT_W | Per-entry transaction budget for interrupt endpoints |
| rl | input | RL_W | NAK reload value; zero disables NAK counting |
| nak_init | input | NAK_W | Starting NAK count loaded on entry |
| fits | input | 1 | Next transaction fits in the current micro-frame |
| active | input | 1 | Queue head Active bit |
| rsp_valid | input | 1 | Transaction result valid |
| rsp_hs | input | 2 | Handshake code: 0 ACK, 1 NAK, 2 NYET, 3 STALL |
| rsp_err | input | 1 | Transaction error |
| rsp_pid_err | input | 1 | Data PID mismatch on IN data |
| rsp_cerr_chg | input | 1 | Error counter changed by this transaction |
| txn_req | output | 1 | Issue one transaction (pulse) |
| reclaim_set | output | 1 | Set the reclamation status bit (pulse) |
| done | output | 1 | State left (pulse) |
| exit_code | output | 3 | Exit reason, valid with `done` |
| wb_req | output | 1 | Overlay write-back request, with `done` |
| nak_cnt | output | NAK_W | Current NAK count |

## Verification
The hardest case to reach is a data PID mismatch on an interrupt IN transaction. Whether that loop goes on depends on the remaining budget after the decrement, so the result must arrive when exactly two units or exactly one unit are left. The stimulus table loads the budget through `mult` and answers each `txn_req` with a scripted sequence of results. It places the mismatch on the first transaction with budgets of 3 and 2, and it places a NAK after an ACK. The same scripts lower `active` or `fits` only in the response cycle, which separates the exits after a transaction from the check at entry.

// File: rtl/qh_exec_pkg.sv
package qh_exec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } exec_st_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_NYET  = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef enum logic [2:0] {
    EX_PID_STOP   = 3'd0,
    EX_PRE_NOFIT  = 3'd1,
    EX_PRE_ZERO   = 3'd2,
    EX_COUNT_DONE = 3'd3,
    EX_HANDSHAKE  = 3'd4,
    EX_XACT_ERR   = 3'd5,
    EX_INACTIVE   = 3'd6,
    EX_NOFIT_NEXT = 3'd7
  } exit_e;

endpackage

// File: rtl/qh_txn_counter.sv
module qh_txn_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rem_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_en | (dec_en & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)      cnt_d = load_val;
    else if (dec_en)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign rem_o = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);

  AST_BUDGET_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_en) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/qh_nak_counter.sv
module qh_nak_counter #(
  parameter int NAK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [NAK_W-1:0] load_val,
  input  logic             dec_en,
  output logic [NAK_W-1:0] nak_o
);

  logic [NAK_W-1:0] nak_q, nak_d;
  logic             nak_en;

  assign nak_en = load_en | (dec_en & (nak_q != '0));

  always_comb begin
    nak_d = nak_q;
    if (load_en)      nak_d = load_val;
    else if (dec_en)  nak_d = nak_q - NAK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       nak_q <= '0;
    else if (nak_en)  nak_q <= nak_d;
  end

  assign nak_o = nak_q;

  AST_NAK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_q == '0 && !load_en) |=> (nak_q == '0)); // R10

endmodule

// File: rtl/qh_exit_decode.sv
module qh_exit_decode
  import qh_exec_pkg::*;
#(
  parameter int CNT_W = 2,
  parameter int RL_W  = 4
) (
  input  logic [1:0]       hs,
  input  logic             err,
  input  logic             pid_err,
  input  logic             cerr_chg,
  input  logic             active,
  input  logic             fits,
  input  logic             is_intr,
  input  logic             is_in,
  input  logic [RL_W-1:0]  rl,
  input  logic [CNT_W-1:0] rem,
  output logic             stop,
  output exit_e            code,
  output logic             wb,
  output logic             nak_dec
);

  logic nak_like;
  logic pid_hit;
  logic pid_go_on;

  assign nak_like  = (hs == HS_NAK) || (hs == HS_NYET);
  assign pid_hit   = pid_err & is_in;
  assign pid_go_on = is_intr && (rem > CNT_W'(1));
  assign nak_dec   = !err && nak_like && is_in && (rl != '0);

  always_comb begin
    stop = 1'b1;
    code = EX_COUNT_DONE;
    wb   = 1'b1;
    if (err) begin
      code = EX_XACT_ERR;
    end else if (hs != HS_ACK) begin
      code = EX_HANDSHAKE;
      wb   = !(nak_like && (rl == '0) && !cerr_chg);
    end else if (pid_hit && !pid_go_on) begin
      code = EX_PID_STOP;
    end else if (rem == '0) begin
      code = EX_COUNT_DONE;
    end else if (!active) begin
      code = EX_INACTIVE;
    end else if (!fits) begin
      code = EX_NOFIT_NEXT;
    end else begin
      stop = 1'b0;
    end
  end

endmodule

// File: rtl/qh_exec_ctrl.sv
module qh_exec_ctrl
  import qh_exec_pkg::*;
#(
  parameter int CNT_W = 2,
  parameter int NAK_W = 4,
  parameter int RL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_intr,
  input  logic             is_in,
  input  logic [CNT_W-1:0] mult,
  input  logic [RL_W-1:0]  rl,
  input  logic [NAK_W-1:0] nak_init,
  input  logic             fits,
  input  logic             active,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_hs,
  input  logic             rsp_err,
  input  logic             rsp_pid_err,
  input  logic             rsp_cerr_chg,
  output logic             txn_req,
  output logic             reclaim_set,
  output logic             done,
  output logic [2:0]       exit_code,
  output logic             wb_req,
  output logic [NAK_W-1:0] nak_cnt
);

  localparam logic [CNT_W-1:0] ASYNC_BUDGET = CNT_W'(1);

  exec_st_e         st_q, st_d;
  exit_e            exit_q, exit_d;
  logic             wb_q, wb_d;
  logic             ctl_en;

  logic             cnt_load, cnt_dec;
  logic [CNT_W-1:0] cnt_load_val, cnt, rem;
  logic             nak_load, nak_dec_en;

  logic             dec_stop, dec_wb, dec_nak;
  exit_e            dec_code;

  assign cnt_load_val = is_intr ? mult : ASYNC_BUDGET;

  qh_txn_counter #(.CNT_W(CNT_W)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (cnt_load),
    .load_val (cnt_load_val),
    .dec_en   (cnt_dec),
    .cnt_o    (cnt),
    .rem_o    (rem)
  );

  qh_nak_counter #(.NAK_W(NAK_W)) u_nak (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (nak_load),
    .load_val (nak_init),
    .dec_en   (nak_dec_en),
    .nak_o    (nak_cnt)
  );

  qh_exit_decode #(.CNT_W(CNT_W), .RL_W(RL_W)) u_decode (
    .hs       (rsp_hs),
    .err      (rsp_err),
    .pid_err  (rsp_pid_err),
    .cerr_chg (rsp_cerr_chg),
    .active   (active),
    .fits     (fits),
    .is_intr  (is_intr),
    .is_in    (is_in),
    .rl       (rl),
    .rem      (rem),
    .stop     (dec_stop),
    .code     (dec_code),
    .wb       (dec_wb),
    .nak_dec  (dec_nak)
  );

  always_comb begin
    st_d        = st_q;
    exit_d      = exit_q;
    wb_d        = wb_q;
    cnt_load    = 1'b0;
    cnt_dec     = 1'b0;
    nak_load    = 1'b0;
    nak_dec_en  = 1'b0;
    reclaim_set = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_CHECK;
          cnt_load = 1'b1;
          nak_load = 1'b1;
        end
      end
      ST_CHECK: begin
        if (!fits) begin
          exit_d = EX_PRE_NOFIT;
          wb_d   = 1'b0;
          st_d   = ST_DONE;
        end else if (is_intr && (cnt == '0)) begin
          exit_d = EX_PRE_ZERO;
          wb_d   = 1'b0;
          st_d   = ST_DONE;
        end else begin
          reclaim_set = 1'b1;
          st_d        = ST_ISSUE;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid) begin
          cnt_dec    = 1'b1;
          nak_dec_en = dec_nak;
          if (dec_stop) begin
            exit_d = dec_code;
            wb_d   = dec_wb;
            st_d   = ST_DONE;
          end else begin
            st_d = ST_ISSUE;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      exit_q <= EX_PID_STOP;
      wb_q   <= 1'b0;
    end else if (ctl_en) begin
      st_q   <= st_d;
      exit_q <= exit_d;
      wb_q   <= wb_d;
    end
  end

  assign txn_req   = (st_q == ST_ISSUE);
  assign done      = (st_q == ST_DONE);
  assign exit_code = exit_q;
  assign wb_req    = done & wb_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_PRE_EXIT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (exit_code == EX_PRE_NOFIT || exit_code == EX_PRE_ZERO)) |-> !wb_req); // R11

  AST_RECLAIM_LEADS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    reclaim_set |=> txn_req); // R3

  AST_LAST_UNIT_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && rsp_valid && cnt == CNT_W'(1)) |=> done); // R4

  AST_ERR_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && rsp_valid && rsp_err) |=> (done && exit_code == EX_XACT_ERR)); // R6

  AST_ZERO_BUDGET_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && is_intr && cnt == '0) |=> !txn_req); // R2

endmodule

// File: tb/qh_exec_ctrl_test.sv
module qh_exec_ctrl_test;

  typedef struct packed {
    logic            intr;
    logic            dir_in;
    logic [1:0]      mult;
    logic [3:0]      rl;
    logic [3:0]      nak;
    logic            fit0;
    logic [2:0][6:0] rsp;
    logic [1:0]      x_txn;
    logic [2:0]      x_code;
    logic            x_wb;
    logic [3:0]      x_nak;
    logic            x_recl;
  } vec_t;

  // response word: {hs[1:0], err, pid, active, fits, cerr_chg}; rsp[0] answers the first request
  localparam logic [6:0] ACKOK = 7'b00_0_0_1_1_0;
  localparam logic [6:0] NAKOK = 7'b01_0_0_1_1_0;
  localparam logic [6:0] NYETC = 7'b10_0_0_1_1_1;
  localparam logic [6:0] STERR = 7'b11_1_0_1_1_0;
  localparam logic [6:0] ACKA0 = 7'b00_0_0_0_1_0;
  localparam logic [6:0] ACKF0 = 7'b00_0_0_1_0_0;
  localparam logic [6:0] ACKPD = 7'b00_0_1_1_1_0;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,2'd2,4'd0,4'd0,1'b0,{ACKOK,ACKOK,ACKOK},2'd0,3'd1,1'b0,4'd0,1'b0},
    '{1'b1,1'b0,2'd0,4'd0,4'd0,1'b1,{ACKOK,ACKOK,ACKOK},2'd0,3'd2,1'b0,4'd0,1'b0},
    '{1'b1,1'b0,2'd3,4'd0,4'd0,1'b1,{ACKOK,ACKOK,ACKOK},2'd3,3'd3,1'b1,4'd0,1'b1},
    '{1'b0,1'b0,2'd3,4'd0,4'd0,1'b1,{ACKOK,ACKOK,ACKOK},2'd1,3'd3,1'b1,4'd0,1'b1},
    '{1'b1,1'b1,2'd3,4'd4,4'd5,1'b1,{ACKOK,ACKOK,NAKOK},2'd1,3'd4,1'b1,4'd4,1'b1},
    '{1'b0,1'b1,2'd0,4'd0,4'd5,1'b1,{ACKOK,ACKOK,NAKOK},2'd1,3'd4,1'b0,4'd5,1'b1},
    '{1'b0,1'b1,2'd0,4'd0,4'd5,1'b1,{ACKOK,ACKOK,NYETC},2'd1,3'd4,1'b1,4'd5,1'b1},
    '{1'b1,1'b1,2'd3,4'd4,4'd5,1'b1,{ACKOK,ACKOK,STERR},2'd1,3'd5,1'b1,4'd5,1'b1},
    '{1'b1,1'b0,2'd3,4'd0,4'd0,1'b1,{ACKOK,ACKOK,ACKA0},2'd1,3'd6,1'b1,4'd0,1'b1},
    '{1'b1,1'b0,2'd3,4'd0,4'd0,1'b1,{ACKOK,ACKOK,ACKF0},2'd1,3'd7,1'b1,4'd0,1'b1},
    '{1'b1,1'b1,2'd3,4'd0,4'd0,1'b1,{ACKOK,ACKOK,ACKPD},2'd3,3'd3,1'b1,4'd0,1'b1},
    '{1'b1,1'b1,2'd2,4'd0,4'd0,1'b1,{ACKOK,ACKOK,ACKPD},2'd1,3'd0,1'b1,4'd0,1'b1},
    '{1'b1,1'b0,2'd3,4'd4,4'd5,1'b1,{ACKOK,ACKOK,NAKOK},2'd1,3'd4,1'b1,4'd5,1'b1},
    '{1'b1,1'b1,2'd3,4'd4,4'd5,1'b1,{ACKOK,NAKOK,ACKOK},2'd2,3'd4,1'b1,4'd4,1'b1},
    '{1'b0,1'b1,2'd3,4'd0,4'd0,1'b1,{ACKOK,ACKOK,ACKPD},2'd1,3'd0,1'b1,4'd0,1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       is_intr = 1'b0;
  logic       is_in = 1'b0;
  logic [1:0] mult = '0;
  logic [3:0] rl = '0;
  logic [3:0] nak_init = '0;
  logic       fits = 1'b0;
  logic       active = 1'b0;
  logic       rsp_valid = 1'b0;
  logic [1:0] rsp_hs = '0;
  logic       rsp_err = 1'b0;
  logic       rsp_pid_err = 1'b0;
  logic       rsp_cerr_chg = 1'b0;
  logic       txn_req, reclaim_set, done, wb_req;
  logic [2:0] exit_code;
  logic [3:0] nak_cnt;

  int checks = 0;
  int fails  = 0;
  int r_txn, r_code, r_wb, r_recl, r_recl_late, r_done, r_after;

  always #4 clk = ~clk;

  qh_exec_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_intr(is_intr), .is_in(is_in),
    .mult(mult), .rl(rl), .nak_init(nak_init), .fits(fits), .active(active),
    .rsp_valid(rsp_valid), .rsp_hs(rsp_hs), .rsp_err(rsp_err),
    .rsp_pid_err(rsp_pid_err), .rsp_cerr_chg(rsp_cerr_chg),
    .txn_req(txn_req), .reclaim_set(reclaim_set), .done(done),
    .exit_code(exit_code), .wb_req(wb_req), .nak_cnt(nak_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string code_tag(input int c);
    case (c)
      1: return "R1";
      2: return "R2";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input vec_t v, input bit restart);
    int idx;
    bit arm;
    idx = 0; arm = 1'b0;
    r_txn = 0; r_code = -1; r_wb = -1; r_recl = 0; r_recl_late = 0; r_done = 0; r_after = 0;
    @(negedge clk);
    is_intr = v.intr; is_in = v.dir_in; mult = v.mult; rl = v.rl; nak_init = v.nak;
    fits = v.fit0; active = 1'b1; start = 1'b1;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      start = 1'b0; rsp_valid = 1'b0;
      if (reclaim_set) begin
        r_recl++;
        if (r_txn != 0) r_recl_late++;
      end
      if (done) begin
        r_done = 1; r_code = int'(exit_code); r_wb = int'(wb_req);
        @(negedge clk);
        r_after = int'(done);
        break;
      end
      if (arm) begin
        rsp_valid = 1'b1;
        rsp_hs = v.rsp[idx][6:5]; rsp_err = v.rsp[idx][4]; rsp_pid_err = v.rsp[idx][3];
        active = v.rsp[idx][2]; fits = v.rsp[idx][1]; rsp_cerr_chg = v.rsp[idx][0];
        start = restart;
        if (idx < 2) idx++;
        arm = 1'b0;
      end
      if (txn_req) begin
        r_txn++;
        arm = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    // reset state: R12 done low, R3 no reclaim, R10 count cleared
    chk("R12 reset done", int'(done), 0);
    chk("R3 reset reclaim", int'(reclaim_set), 0);
    chk("R4 reset txn_req", int'(txn_req), 0);
    chk("R11 reset wb_req", int'(wb_req), 0);
    chk("R10 reset nak_cnt", int'(nak_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i], 1'b0);
      chk("R12 done seen", r_done, 1);
      chk("R12 done one cycle", r_after, 0);
      chk({code_tag(int'(VEC[i].x_code)), " exit code"}, r_code, int'(VEC[i].x_code));
      chk("R4 request count", r_txn, int'(VEC[i].x_txn));
      chk("R11 write-back", r_wb, int'(VEC[i].x_wb));
      chk("R10 nak count", int'(nak_cnt), int'(VEC[i].x_nak));
      chk("R3 reclaim pulses", r_recl, int'(VEC[i].x_recl));
      chk("R3 reclaim before first request", r_recl_late, 0);
    end

    // R12: results with no request outstanding are ignored
    @(negedge clk);
    rsp_valid = 1'b1; rsp_err = 1'b1; rsp_hs = 2'd3;
    r_done = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || txn_req) r_done = 1;
    end
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_hs = 2'd0;
    chk("R12 idle result ignored", r_done, 0);

    // R12: start pulses while engaged do not disturb a three-request run
    run(VEC[2], 1'b1);
    chk("R12 restart ignored count", r_txn, 3);
    chk("R12 restart ignored code", r_code, 3);

    // R10: NAK with count already zero stays at zero
    d = VEC[4];
    d.nak = 4'd0; d.rl = 4'd3;
    run(d, 1'b0);
    chk("R10 nak floor", int'(nak_cnt), 0);
    chk("R5 nak floor exit", r_code, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule